// File: doc/BRIEF.md
# Dual-Channel PWM with Phase-Offset Mode

This block drives two pulse-width modulated outputs from one system clock. A plain write strobe with a small address and a 16-bit data word loads two period registers, two on-time registers and a single mode bit. Both channels count in ticks of two clock cycles. One channel's period spans 2 × (period + 1) clocks. Its high time spans 2 × on-time clocks, so any duty from 0% to 100% can be set.

With the mode bit set, the two channels are independent: each one uses its own period and on-time. With the mode bit clear (the state after reset), both channels share the channel-0 period. The channel-1 period register then sets how long the channel-1 rising edge trails the channel-0 rising edge. A new on-time is held in a shadow until the next cycle of its channel starts. A write to a period register or to the mode bit restarts both channels and the tick divider at once.

Each channel is a two-state machine. In CH_RUN the cycle counter advances on every tick, wraps at the period limit and reloads the on-time on the wrap. In CH_DELAY (used only by channel 1 in offset mode) a delay counter advances instead and no pulse is produced. The transitions are:
- RESTART_TO_RUN: any restart, for channel 0 or in independent mode.
- RESTART_TO_DELAY: a restart of channel 1 in offset mode.
- DELAY_DONE: leaves CH_DELAY for CH_RUN once the delay count is reached.
- RUN_WRAP: stays in CH_RUN and begins a new cycle.

Top module: `pwm_dual_offset`

## Requirements
- R1: The tick divider asserts a tick on every second clock. A channel's cycle counter advances once per tick and wraps after its period limit, so one period lasts 2 × (limit + 1) clocks.
- R2: A channel's output is high for the first 2 × on-time clocks of each cycle. An on-time of 0 gives an output that is low for the whole cycle, with no glitch at the cycle start.
- R3: When the active on-time exceeds the channel's period limit, the output stays high without a break.
- R4: With the mode bit at 1, channel 1 uses its own period register (address 1) as its period limit.
- R5: With the mode bit at 0, both channels use the channel-0 period. After a restart, channel 1 stays low for 2 × (channel-1 period register + 1) clocks and then starts its cycles. It wraps on the shared period from that point on.
- R6: An on-time written to address 2 (channel 0) or address 3 (channel 1) has no effect on the output until the channel's next cycle start.
- R7: A write to address 0 (channel-0 period) or address 1 (channel-1 period) takes effect on that clock edge. It clears both cycle counters, the delay counter and the tick divider, and both channels start a new cycle in the next clock.
- R8: After reset, both period registers hold 0xFFFF, both on-time registers hold 0, the mode bit is 0, and both outputs are low.
- R9: A write to address 4 loads the mode bit from data bit 0 and restarts both channels in the same way as a period write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register select: 0 period0, 1 period1, 2 on-time0, 3 on-time1, 4 mode |
| wr_data | input | 16 | Write data |
| pwm0 | output | 1 | Channel-0 PWM output |
| pwm1 | output | 1 | Channel-1 PWM output |

## Verification
The hardest case to reach is an on-time update that arrives in the middle of a running cycle. It must wait in the shadow for exactly one cycle boundary. To hit it, the stimulus waits for a known clock offset after a restart, writes the new value halfway through a pulse, and checks that the old width finishes before the new width appears. A second hard case is a mode-bit write while the counters are running on an odd divider phase. The stimulus places that write at an odd clock count after the last restart. This way, a missing restart shows up both as a wrong tick phase and as channel 1 not re-entering its delay.

// File: rtl/pwm_dual_pkg.sv
`timescale 1ns/1ps
package pwm_dual_pkg;
    localparam int ADDR_W = 3;
    localparam logic [ADDR_W-1:0] A_PER0  = 3'd0;
    localparam logic [ADDR_W-1:0] A_PER1  = 3'd1;
    localparam logic [ADDR_W-1:0] A_ON0   = 3'd2;
    localparam logic [ADDR_W-1:0] A_ON1   = 3'd3;
    localparam logic [ADDR_W-1:0] A_MODE  = 3'd4;

    typedef enum logic {
        CH_RUN   = 1'b0,
        CH_DELAY = 1'b1
    } ch_state_t;
endpackage

// File: rtl/pwm_tick_div.sv
`timescale 1ns/1ps
module pwm_tick_div (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    output logic tick
);
    logic half_q;

    always_ff @(posedge clk) begin
        if (!rst_n)     half_q <= 1'b0;
        else if (clear) half_q <= 1'b0;
        else            half_q <= ~half_q;
    end

    assign tick = half_q;

    assert_tick_alternates_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !clear) |=> !tick);
endmodule

// File: rtl/pwm_chan.sv
`timescale 1ns/1ps
module pwm_chan
    import pwm_dual_pkg::*;
#(
    parameter int        W           = 16,
    parameter bit        RST_DELAYED = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         restart,
    input  logic         delayed_start,
    input  logic [W-1:0] period_lim,
    input  logic [W-1:0] delay_lim,
    input  logic [W-1:0] on_next,
    output logic         pwm
);
    ch_state_t    state_q, state_d;
    logic [W-1:0] cnt_q, cnt_d;
    logic [W-1:0] dly_q, dly_d;
    logic [W-1:0] on_q,  on_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RST_DELAYED ? CH_DELAY : CH_RUN;
            cnt_q   <= '0;
            dly_q   <= '0;
            on_q    <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            dly_q   <= dly_d;
            on_q    <= on_d;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        dly_d   = dly_q;
        on_d    = on_q;
        if (restart) begin
            state_d = delayed_start ? CH_DELAY : CH_RUN;
            cnt_d   = '0;
            dly_d   = '0;
            on_d    = on_next;
        end else if (tick) begin
            unique case (state_q)
                CH_RUN: begin
                    if (cnt_q == period_lim) begin
                        cnt_d = '0;
                        on_d  = on_next;
                    end else begin
                        cnt_d = cnt_q + W'(1);
                    end
                end
                CH_DELAY: begin
                    if (dly_q == delay_lim) begin
                        state_d = CH_RUN;
                        cnt_d   = '0;
                        on_d    = on_next;
                    end else begin
                        dly_d = dly_q + W'(1);
                    end
                end
                default: ;
            endcase
        end
    end

    // output logic
    always_comb begin
        pwm = (state_q == CH_RUN) && (cnt_q < on_q);
    end

    assert_cnt_wrap_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_RUN && tick && cnt_q == period_lim && !restart) |=> cnt_q == '0);
    assert_cnt_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_RUN) |-> cnt_q <= period_lim);
    assert_full_on_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_RUN && on_q > period_lim) |-> pwm);
    assert_delay_exit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_DELAY && tick && dly_q == delay_lim && !restart)
        |=> (state_q == CH_RUN && cnt_q == '0));
    assert_shadow_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_RUN && !restart && !(tick && cnt_q == period_lim)) |=> $stable(on_q));
    assert_restart_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (cnt_q == '0 && dly_q == '0));
endmodule

// File: rtl/pwm_dual_offset.sv
`timescale 1ns/1ps
module pwm_dual_offset
    import pwm_dual_pkg::*;
#(
    parameter int W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [W-1:0]      wr_data,
    output logic              pwm0,
    output logic              pwm1
);
    localparam int NCH = 2;

    logic [W-1:0] per_q [NCH];
    logic [W-1:0] on_q  [NCH];
    logic         mode_q;
    logic         mode_nxt;
    logic         per_wr, mode_wr, restart, tick;
    logic [NCH-1:0] pwm_v;

    assign per_wr   = wr_en && (wr_addr == A_PER0 || wr_addr == A_PER1);
    assign mode_wr  = wr_en && (wr_addr == A_MODE);
    assign restart  = per_wr || mode_wr;
    assign mode_nxt = mode_wr ? wr_data[0] : mode_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            per_q[0] <= '1;
            per_q[1] <= '1;
            on_q[0]  <= '0;
            on_q[1]  <= '0;
            mode_q   <= 1'b0;
        end else if (wr_en) begin
            unique case (wr_addr)
                A_PER0:  per_q[0] <= wr_data;
                A_PER1:  per_q[1] <= wr_data;
                A_ON0:   on_q[0]  <= wr_data;
                A_ON1:   on_q[1]  <= wr_data;
                A_MODE:  mode_q   <= wr_data[0];
                default: ;
            endcase
        end
    end

    pwm_tick_div u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (restart),
        .tick  (tick)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        logic [W-1:0] lim;
        logic         dstart;
        if (g == 0) begin : g_lead
            assign lim    = per_q[0];
            assign dstart = 1'b0;
        end else begin : g_follow
            assign lim    = mode_q ? per_q[1] : per_q[0];
            assign dstart = ~mode_nxt;
        end
        pwm_chan #(.W(W), .RST_DELAYED(g != 0)) u_ch (
            .clk           (clk),
            .rst_n         (rst_n),
            .tick          (tick),
            .restart       (restart),
            .delayed_start (dstart),
            .period_lim    (lim),
            .delay_lim     (per_q[1]),
            .on_next       (on_q[g]),
            .pwm           (pwm_v[g])
        );
    end

    assign pwm0 = pwm_v[0];
    assign pwm1 = pwm_v[1];

    assert_restart_tick_R7: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !tick);
    assert_mode_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mode_wr |=> mode_q == $past(wr_data[0]));
    assert_reset_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!pwm0 && !pwm1));
endmodule

// File: tb/test_pwm_dual_offset.sv
`timescale 1ns/1ps
module test_pwm_dual_offset;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        pwm0, pwm1;
    int          n_tests = 0;
    int          n_fail  = 0;
    bit          done    = 1'b0;

    always #2 clk = ~clk;

    pwm_dual_offset i_pwm_dual_offset (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .pwm0(pwm0), .pwm1(pwm1)
    );

    // {mode, per0, per1, on0, on1}
    localparam logic [64:0] VECS [0:5] = '{
        {1'b1, 16'd4, 16'd6, 16'd2,  16'd3},
        {1'b1, 16'd3, 16'd2, 16'd0,  16'd9},
        {1'b0, 16'd7, 16'd2, 16'd3,  16'd4},
        {1'b0, 16'd5, 16'd3, 16'd6,  16'd5},
        {1'b1, 16'd0, 16'd1, 16'd1,  16'd1},
        {1'b0, 16'd9, 16'd0, 16'd10, 16'd0}
    };

    function automatic logic exp_ch0(int t, int p0, int on0);
        return ((t / 2) % (p0 + 1)) < on0;
    endfunction

    function automatic logic exp_ch1(int t, bit mode, int p0, int p1, int on1);
        int d;
        if (mode) return ((t / 2) % (p1 + 1)) < on1;
        d = 2 * (p1 + 1);
        if (t < d) return 1'b0;
        return (((t - d) / 2) % (p0 + 1)) < on1;
    endfunction

    task automatic check(string req, logic act, logic exp, int t);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s t=%0d actual=%b expected=%b", req, t, act, exp);
        end
    endtask

    // returns at the first negedge after the write edge (t = 0)
    task automatic wr(logic [2:0] a, logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic run_cmp(string req, int n, bit mode, int p0, int p1, int on0, int on1);
        for (int t = 0; t < n; t++) begin
            check(req, pwm0, exp_ch0(t, p0, on0), t);
            check(req, pwm1, exp_ch1(t, mode, p0, p1, on1), t);
            @(negedge clk);
        end
    endtask

    initial begin
        #800000;
        if (!done) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R8: reset state, outputs low
        for (int i = 0; i < 40; i++) begin
            check("R8", pwm0, 1'b0, i);
            check("R8", pwm1, 1'b0, i);
            @(negedge clk);
        end
        // R6: on-time writes without a cycle start have no effect
        wr(3'd2, 16'd5);
        wr(3'd3, 16'd5);
        for (int i = 0; i < 40; i++) begin
            check("R6", pwm0, 1'b0, i);
            check("R6", pwm1, 1'b0, i);
            @(negedge clk);
        end

        // table walk: R1 R2 R3 R4 R5 R7
        for (int k = 0; k < 6; k++) begin
            logic [64:0] v;
            v = VECS[k];
            wr(3'd2, v[31:16]);
            wr(3'd3, v[15:0]);
            wr(3'd1, v[47:32]);
            wr(3'd4, {15'd0, v[64]});
            wr(3'd0, v[63:48]);
            run_cmp("R1/R2/R3/R4/R5/R7", 121, v[64], int'(v[63:48]), int'(v[47:32]),
                    int'(v[31:16]), int'(v[15:0]));
        end

        // R6: mid-cycle on-time write waits for next cycle start
        wr(3'd2, 16'd3);
        wr(3'd3, 16'd3);
        wr(3'd1, 16'd9);
        wr(3'd4, 16'd1);
        wr(3'd0, 16'd9);
        for (int t = 0; t < 60; t++) begin
            check("R6", pwm0, exp_ch0(t, 9, (t < 20) ? 3 : 7), t);
            check("R6", pwm1, exp_ch1(t, 1'b1, 9, 9, 3), t);
            if (t == 5) begin
                wr_en = 1'b1; wr_addr = 3'd2; wr_data = 16'd7;
            end
            if (t == 6) wr_en = 1'b0;
            @(negedge clk);
        end

        // R9: mode write at odd phase restarts both channels
        wr(3'd2, 16'd2);
        wr(3'd3, 16'd2);
        wr(3'd1, 16'd3);
        wr(3'd4, 16'd1);
        wr(3'd0, 16'd5);
        run_cmp("R4", 7, 1'b1, 5, 3, 2, 2);
        wr(3'd4, 16'd0);
        run_cmp("R9", 60, 1'b0, 5, 3, 2, 2);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule